// File: doc/BRIEF.md
# Lane-Segmented SIMD Adder ALU

This block is one 64-bit slice of a SIMD integer datapath. It treats its two operands as packed lanes of 8, 16 or 32 bits and applies one of eleven integer operations to every lane at once: wrapping add and subtract, saturating add and subtract, truncating and rounding average, minimum, maximum, absolute value, absolute difference and negate. A single input selects signed or unsigned behaviour. Eight slices side by side give a 512-bit vector unit.

All of the arithmetic comes from one byte-sliced carry-chain adder. The carry chain is cut at every lane boundary. Subtraction inverts the second operand and forces the carry-in high. The rounding average takes its +1 from the same carry-in. Each lane is treated as one bit wider than its width, and a guard bit holds the lane's exact carry or sign. Saturation and averaging read that guard bit. A second copy of the adder always forms a−b. Its guard bit is the per-lane "a below b" decision that minimum, maximum and absolute difference use. The result is registered on the clock edge where the valid strobe is sampled high.

Top module: `seg_simd_alu`

## Requirements
- R1: On reset, `res_o` and `vld_o` are zero. On a rising edge with `valid_i` high, the result is loaded into `res_o` and `vld_o` goes high for the next cycle. When `valid_i` is low, `vld_o` is low on the following cycle and `res_o` keeps its previous value.
- R2: `width_i` selects the lane width: 0 gives 8-bit lanes, 1 gives 16-bit lanes, 2 gives 32-bit lanes, and 3 also gives 32-bit lanes. No carry or borrow crosses from one lane into the next.
- R3: Opcode 0 (add) and opcode 1 (subtract) produce (a+b) mod 2^w and (a−b) mod 2^w in each lane, for either signedness.
- R4: With `signed_i`=1, opcode 2 (saturating add) and opcode 3 (saturating subtract) clamp each lane's exact result to the range from −2^(w−1) to 2^(w−1)−1. For 16-bit lanes the limits are 0x8000 and 0x7fff.
- R5: With `signed_i`=0, opcodes 2 and 3 clamp each lane's exact result to the range from 0 to 2^w−1.
- R6: Opcode 4 gives floor((a+b)/2) per lane. Opcode 5 gives floor((a+b+1)/2). Both are exact over the full w+1-bit sum, in the selected signedness.
- R7: Opcode 6 gives the smaller of a and b per lane, and opcode 7 gives the larger. The comparison is two's-complement when `signed_i`=1 and unsigned otherwise.
- R8: Opcode 8 gives |a| mod 2^w when signed, so the most negative value maps to itself. When unsigned, it returns a unchanged.
- R9: Opcode 9 gives |a−b| per lane as a w-bit unsigned magnitude. The sign of the difference is taken in the selected signedness.
- R10: Opcode 10 gives (0−a) mod 2^w per lane for either signedness.
- R11: Opcodes 11 to 15 behave as opcode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operands and controls are valid this cycle |
| op_i | input | 4 | Operation code |
| width_i | input | 2 | Lane width select |
| signed_i | input | 1 | 1 = signed lanes, 0 = unsigned lanes |
| a_i | input | 64 | First packed operand |
| b_i | input | 64 | Second packed operand |
| vld_o | output | 1 | Result register was loaded on the last edge |
| res_o | output | 64 | Registered packed result |

## Verification
The bench targets the following corner cases:

- **Lane boundaries.** All-ones plus one in every lane must give zero with nothing carried across. A design that leaked the carry would set the low bit of the next lane.
- **Saturation edges.** The bench uses the largest positive value, the most negative value, and unsigned overflow and underflow. A design that lost the guard bit would wrap instead of clamping, or would clamp to the wrong limit.
- **Signedness.** 0x80 against 0x01 and −1 averaged with 0 are run both ways. Choosing the wrong extension flips the minimum and maximum and rounds the average toward the wrong value.
- **Absolute value of the most negative value, and the ignored strobe.** A design that saturated would return 0x7f for the absolute value. A design that ignored the strobe would overwrite the held result.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    localparam int SLICE_W = 64;
    localparam int BYTE_W  = 8;

    typedef enum logic [1:0] {
        LW_8   = 2'd0,
        LW_16  = 2'd1,
        LW_32  = 2'd2,
        LW_32X = 2'd3
    } lane_w_e;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_ADDS = 4'd2,
        OP_SUBS = 4'd3,
        OP_AVG  = 4'd4,
        OP_AVGR = 4'd5,
        OP_MIN  = 4'd6,
        OP_MAX  = 4'd7,
        OP_ABS  = 4'd8,
        OP_ABSD = 4'd9,
        OP_NEG  = 4'd10
    } alu_op_e;

    // Operand set fed to one segmented adder
    typedef struct packed {
        logic [SLICE_W-1:0] x;
        logic [SLICE_W-1:0] y;
        logic               yinv;  // y is the inverted form of an operand
        logic               cin;   // carry injected at every lane start
    } add_in_t;

    // True when byte k begins a new lane for the given width
    function automatic logic lane_start(input int unsigned k, input lane_w_e lw);
        case (lw)
            LW_8:    return 1'b1;
            LW_16:   return (k % 2) == 0;
            default: return (k % 4) == 0;
        endcase
    endfunction

endpackage

// File: rtl/lane_seg_adder.sv
module lane_seg_adder
    import simd_alu_pkg::*;
#(
    parameter int DW = SLICE_W
) (
    input  logic [DW-1:0]        x,
    input  logic [DW-1:0]        y,
    input  logic                 yinv,
    input  logic                 cin,
    input  logic                 sgn,
    input  lane_w_e              lw,
    output logic [DW-1:0]        sum,
    output logic [DW/BYTE_W-1:0] grd
);
    localparam int NB = DW / BYTE_W;

    for (genvar k = 0; k < NB; k++) begin : g_byte
        logic       ci;
        logic [8:0] s9;
        logic       xext;
        logic       yext;

        if (k == 0) begin : g_first
            assign ci = cin;
        end else begin : g_rest
            // carry chain broken at lane starts, carry-in reinjected there
            assign ci = lane_start(k, lw) ? cin : g_byte[k-1].s9[8];
        end

        assign s9   = {1'b0, x[BYTE_W*k +: BYTE_W]} + {1'b0, y[BYTE_W*k +: BYTE_W]} + {8'd0, ci};
        assign sum[BYTE_W*k +: BYTE_W] = s9[7:0];

        // guard bit: sign or zero extension of each operand plus the carry out
        assign xext = sgn & x[BYTE_W*k + 7];
        assign yext = sgn ? y[BYTE_W*k + 7] : yinv;
        assign grd[k] = xext ^ yext ^ s9[8];
    end

endmodule

// File: rtl/lane_post.sv
module lane_post
    import simd_alu_pkg::*;
#(
    parameter int DW = SLICE_W,
    parameter int LB = 8
) (
    input  alu_op_e              op,
    input  logic                 sgn,
    input  logic [DW-1:0]        a,
    input  logic [DW-1:0]        b,
    input  logic [DW-1:0]        msum,
    input  logic [DW/BYTE_W-1:0] mgrd,
    input  logic [DW-1:0]        dsum,
    input  logic [DW/BYTE_W-1:0] dgrd,
    output logic [DW-1:0]        res
);
    localparam int NL  = DW / LB;
    localparam int LBY = LB / BYTE_W;
    localparam logic [LB-1:0] SMAX = {1'b0, {(LB-1){1'b1}}};
    localparam logic [LB-1:0] SMIN = {1'b1, {(LB-1){1'b0}}};

    for (genvar i = 0; i < NL; i++) begin : g_lane
        localparam int LO = i * LB;
        localparam int TB = (i + 1) * LBY - 1;

        logic [LB-1:0] la, lb, m, d, r;
        logic          g, a_lt_b, a_neg;

        assign la     = a[LO +: LB];
        assign lb     = b[LO +: LB];
        assign m      = msum[LO +: LB];
        assign d      = dsum[LO +: LB];
        assign g      = mgrd[TB];
        assign a_lt_b = dgrd[TB];
        assign a_neg  = sgn & la[LB-1];

        always_comb begin
            case (op)
                OP_ADDS, OP_SUBS: begin
                    if (sgn)
                        r = (g != m[LB-1]) ? (g ? SMIN : SMAX) : m;
                    else
                        r = g ? ((op == OP_ADDS) ? {LB{1'b1}} : {LB{1'b0}}) : m;
                end
                OP_AVG, OP_AVGR: r = {g, m[LB-1:1]};
                OP_MIN:          r = a_lt_b ? la : lb;
                OP_MAX:          r = a_lt_b ? lb : la;
                OP_ABS:          r = a_neg ? m : la;
                OP_ABSD:         r = a_lt_b ? m : d;
                default:         r = m;
            endcase
        end

        assign res[LO +: LB] = r;
    end

endmodule

// File: rtl/seg_simd_alu.sv
module seg_simd_alu
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = SLICE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [3:0]        op_i,
    input  logic [1:0]        width_i,
    input  logic              signed_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic              vld_o,
    output logic [DATA_W-1:0] res_o
);
    localparam int NBYTE  = DATA_W / BYTE_W;
    localparam int NWIDTH = 3;

    alu_op_e           opc;
    lane_w_e           lw;
    add_in_t           mi;
    add_in_t           di;
    logic [DATA_W-1:0] m_sum, d_sum, nxt;
    logic [NBYTE-1:0]  m_grd, d_grd;
    logic [DATA_W-1:0] cand [NWIDTH];

    assign opc = alu_op_e'(op_i);
    assign lw  = lane_w_e'(width_i);

    // Main adder operand steering: invert + carry-in gives the subtract forms
    always_comb begin
        mi.x    = a_i;
        mi.y    = b_i;
        mi.yinv = 1'b0;
        mi.cin  = 1'b0;
        case (opc)
            OP_SUB, OP_SUBS: begin
                mi.y = ~b_i; mi.yinv = 1'b1; mi.cin = 1'b1;
            end
            OP_AVGR: mi.cin = 1'b1;
            OP_NEG, OP_ABS: begin
                mi.x = '0; mi.y = ~a_i; mi.yinv = 1'b1; mi.cin = 1'b1;
            end
            OP_ABSD: begin
                mi.x = b_i; mi.y = ~a_i; mi.yinv = 1'b1; mi.cin = 1'b1;
            end
            default: ;
        endcase
    end

    // Comparison adder always forms a - b
    assign di = '{x: a_i, y: ~b_i, yinv: 1'b1, cin: 1'b1};

    lane_seg_adder #(.DW(DATA_W)) u_main_add (
        .x(mi.x), .y(mi.y), .yinv(mi.yinv), .cin(mi.cin),
        .sgn(signed_i), .lw(lw), .sum(m_sum), .grd(m_grd)
    );

    lane_seg_adder #(.DW(DATA_W)) u_diff_add (
        .x(di.x), .y(di.y), .yinv(di.yinv), .cin(di.cin),
        .sgn(signed_i), .lw(lw), .sum(d_sum), .grd(d_grd)
    );

    for (genvar j = 0; j < NWIDTH; j++) begin : g_width
        lane_post #(.DW(DATA_W), .LB(BYTE_W << j)) u_post (
            .op(opc), .sgn(signed_i), .a(a_i), .b(b_i),
            .msum(m_sum), .mgrd(m_grd), .dsum(d_sum), .dgrd(d_grd),
            .res(cand[j])
        );
    end

    always_comb begin
        case (lw)
            LW_8:    nxt = cand[0];
            LW_16:   nxt = cand[1];
            default: nxt = cand[2];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
            res_o <= '0;
        end else begin
            vld_o <= valid_i;
            if (valid_i)
                res_o <= nxt;
        end
    end

endmodule

// File: rtl/seg_simd_alu_chk.sv
module seg_simd_alu_chk (
    input logic        clk,
    input logic        rst,
    input logic        valid_i,
    input logic [3:0]  op_i,
    input logic [1:0]  width_i,
    input logic        signed_i,
    input logic [63:0] a_i,
    input logic [63:0] b_i,
    input logic        vld_o,
    input logic [63:0] res_o
);
    AST_VLD_PIPE: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> vld_o); // R1
    AST_VLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> !vld_o); // R1
    AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(res_o)); // R1
    AST_LANE_ISOLATE: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 4'd0 && width_i == 2'd0)
        |=> res_o[15:8] == $past(a_i[15:8] + b_i[15:8])); // R2
    AST_WRAP_ADD32: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 4'd0 && width_i == 2'd2)
        |=> res_o[31:0] == $past(a_i[31:0] + b_i[31:0])); // R3
    AST_USAT_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 4'd2 && !signed_i && width_i == 2'd0)
        |=> res_o[7:0] >= $past(a_i[7:0])); // R5
    AST_UMIN_BOUND: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 4'd6 && !signed_i && width_i == 2'd0)
        |=> (res_o[7:0] <= $past(a_i[7:0])) && (res_o[7:0] <= $past(b_i[7:0]))); // R7
    AST_NEG_SUM16: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 4'd10 && width_i == 2'd1)
        |=> (res_o[15:0] + $past(a_i[15:0])) == 16'd0); // R10
endmodule

bind seg_simd_alu seg_simd_alu_chk u_chk (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .width_i(width_i),
    .signed_i(signed_i), .a_i(a_i), .b_i(b_i), .vld_o(vld_o), .res_o(res_o)
);

// File: tb/seg_simd_alu_tb.sv
module seg_simd_alu_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        valid;
    logic [3:0]  op;
    logic [1:0]  wsel;
    logic        sgn;
    logic [63:0] a, b;
    logic        vld;
    logic [63:0] res;

    int total = 0;
    int bad   = 0;

    seg_simd_alu u_dut (
        .clk(clk), .rst(rst), .valid_i(valid), .op_i(op), .width_i(wsel),
        .signed_i(sgn), .a_i(a), .b_i(b), .vld_o(vld), .res_o(res)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic longint lane_val(input logic [31:0] raw, input int lw, input bit s);
        longint v;
        v = longint'(raw) & ((64'sd1 <<< lw) - 1);
        if (s && raw[lw-1]) v = v - (64'sd1 <<< lw);
        return v;
    endfunction

    // Per-lane behavioural reference
    function automatic logic [63:0] ref_alu(input logic [3:0] o, input logic [1:0] w,
                                            input bit s, input logic [63:0] x, input logic [63:0] y);
        int lw;
        logic [63:0] out;
        longint la, lb, r, lo, hi;
        lw = (w == 2'd0) ? 8 : (w == 2'd1) ? 16 : 32;
        out = '0;
        for (int i = 0; i < 64 / lw; i++) begin
            la = lane_val(32'(x >> (i*lw)), lw, s);
            lb = lane_val(32'(y >> (i*lw)), lw, s);
            lo = s ? -(64'sd1 <<< (lw-1)) : 0;
            hi = s ? (64'sd1 <<< (lw-1)) - 1 : (64'sd1 <<< lw) - 1;
            case (o)
                4'd1: r = la - lb;
                4'd2: begin r = la + lb; if (r > hi) r = hi; if (r < lo) r = lo; end
                4'd3: begin r = la - lb; if (r > hi) r = hi; if (r < lo) r = lo; end
                4'd4: r = (la + lb) >>> 1;
                4'd5: r = (la + lb + 1) >>> 1;
                4'd6: r = (la < lb) ? la : lb;
                4'd7: r = (la > lb) ? la : lb;
                4'd8: r = (la < 0) ? -la : la;
                4'd9: r = (la > lb) ? la - lb : lb - la;
                4'd10: r = -la;
                default: r = la + lb;
            endcase
            r = r & ((64'sd1 <<< lw) - 1);
            out = out | (64'(r) << (i*lw));
        end
        return out;
    endfunction

    function automatic string req_tag(input logic [3:0] o, input bit s);
        case (o)
            4'd0, 4'd1: return "R3";
            4'd2, 4'd3: return s ? "R4" : "R5";
            4'd4, 4'd5: return "R6";
            4'd6, 4'd7: return "R7";
            4'd8: return "R8";
            4'd9: return "R9";
            4'd10: return "R10";
            default: return "R11";
        endcase
    endfunction

    // One valid beat; result visible after the following rising edge
    task automatic run_op(input logic [3:0] o, input logic [1:0] w, input bit s,
                          input logic [63:0] x, input logic [63:0] y, input string tag);
        @(negedge clk);
        op = o; wsel = w; sgn = s; a = x; b = y; valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
        check(tag, res, ref_alu(o, w, s, x, y));
        check("R1 vld", {63'd0, vld}, 64'd1);
    endtask

    task automatic t_reset;
        rst = 1'b1; valid = 1'b0; op = '0; wsel = '0; sgn = 1'b0; a = '0; b = '0;
        repeat (3) @(negedge clk);
        check("R1 reset res", res, 64'd0);
        check("R1 reset vld", {63'd0, vld}, 64'd0);
        rst = 1'b0;
    endtask

    task automatic t_wrap;
        run_op(4'd0, 2'd0, 1'b0, 64'hffff_ffff_ffff_ffff, 64'h0101_0101_0101_0101, "R2 R3 byte wrap");
        check("R2 no cross-lane carry", res, 64'd0);
        run_op(4'd1, 2'd1, 1'b0, 64'h0000_0000_0000_0000, 64'h0001_0001_0001_0001, "R3 sub16");
        check("R3 sub16 literal", res, 64'hffff_ffff_ffff_ffff);
        run_op(4'd0, 2'd3, 1'b0, 64'h0000_0000_ffff_ffff, 64'h0000_0000_0000_0001, "R2 width code 3");
        check("R2 width 3 as 32", res, 64'h0000_0000_0000_0000);
        run_op(4'd0, 2'd2, 1'b1, 64'h7fff_ffff_8000_0000, 64'h0000_0001_ffff_ffff, "R3 add32 signed");
    endtask

    task automatic t_sat_signed;
        run_op(4'd2, 2'd1, 1'b1, 64'h7fff_8000_7fff_0001, 64'h0001_ffff_7fff_0001, "R4 adds16");
        check("R4 adds16 literal", res, 64'h7fff_8000_7fff_0002);
        run_op(4'd3, 2'd0, 1'b1, 64'h80_7f_00_80_7f_00_01_ff, 64'h01_ff_80_7f_80_01_02_7f, "R4 subs8");
        run_op(4'd2, 2'd2, 1'b1, 64'h8000_0000_7fff_fffe, 64'h8000_0000_0000_0005, "R4 adds32");
    endtask

    task automatic t_sat_unsigned;
        run_op(4'd2, 2'd0, 1'b0, 64'hff_80_01_fe_00_7f_c0_10, 64'h01_80_01_05_00_80_40_10, "R5 adds8");
        run_op(4'd3, 2'd1, 1'b0, 64'h0000_0005_ffff_1234, 64'h0001_0006_0001_1234, "R5 subs16");
        check("R5 subs16 literal", res, 64'h0000_0000_fffe_0000);
    endtask

    task automatic t_avg;
        run_op(4'd4, 2'd0, 1'b1, 64'h0000_0000_0000_00ff, 64'h0000_0000_0000_0000, "R6 avg signed -1,0");
        check("R6 avg floor", res, 64'h0000_0000_0000_00ff);
        run_op(4'd5, 2'd0, 1'b1, 64'h0000_0000_0000_00ff, 64'h0000_0000_0000_0000, "R6 avgr signed -1,0");
        check("R6 avgr literal", res, 64'h0000_0000_0000_0000);
        run_op(4'd4, 2'd0, 1'b0, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff, "R6 avg unsigned max");
        run_op(4'd5, 2'd2, 1'b1, 64'h7fff_ffff_8000_0000, 64'h7fff_ffff_8000_0001, "R6 avgr32");
    endtask

    task automatic t_minmax;
        run_op(4'd6, 2'd0, 1'b1, 64'h0000_0000_0000_0080, 64'h0101_0101_0101_0101, "R7 min signed");
        check("R7 min signed literal", res, 64'h0000_0000_0000_0080);
        run_op(4'd6, 2'd0, 1'b0, 64'h0000_0000_0000_0080, 64'h0101_0101_0101_0101, "R7 min unsigned");
        check("R7 min unsigned literal", res, 64'h0000_0000_0000_0001);
        run_op(4'd7, 2'd1, 1'b1, 64'h8000_7fff_0001_ffff, 64'h7fff_8000_ffff_0000, "R7 max16 signed");
        run_op(4'd7, 2'd2, 1'b0, 64'h8000_0000_0000_0001, 64'h7fff_ffff_0000_0001, "R7 max32 unsigned");
    endtask

    task automatic t_abs_neg;
        run_op(4'd8, 2'd0, 1'b1, 64'h80_81_ff_00_7f_01_c0_40, 64'h0, "R8 abs signed");
        check("R8 abs most-negative", {56'd0, res[63:56]}, 64'h80);
        run_op(4'd8, 2'd1, 1'b0, 64'h8000_ffff_0001_1234, 64'h0, "R8 abs unsigned");
        check("R8 abs unsigned literal", res, 64'h8000_ffff_0001_1234);
        run_op(4'd9, 2'd0, 1'b1, 64'h80_7f_00_05_10_ff_01_80, 64'h7f_80_05_00_10_01_ff_80, "R9 absd signed");
        check("R9 absd -128,127", {56'd0, res[63:56]}, 64'hff);
        run_op(4'd9, 2'd2, 1'b0, 64'h0000_0001_ffff_ffff, 64'hffff_ffff_0000_0000, "R9 absd32 unsigned");
        run_op(4'd10, 2'd1, 1'b1, 64'h8000_0001_0000_ffff, 64'h0, "R10 neg16 signed");
        run_op(4'd10, 2'd0, 1'b0, 64'h0102_0304_80ff_0010, 64'h0, "R10 neg8 unsigned");
    endtask

    task automatic t_unused_op;
        for (int o = 11; o < 16; o++)
            run_op(4'(o), 2'd0, 1'b0, 64'h10ff_2080_3001_40fe, 64'h0101_0180_ff01_0102, "R11 unused opcode");
    endtask

    task automatic t_hold;
        logic [63:0] held;
        run_op(4'd0, 2'd1, 1'b0, 64'h1111_2222_3333_4444, 64'h0101_0101_0101_0101, "R1 load");
        held = res;
        @(negedge clk);
        a = 64'hdead_beef_0bad_f00d; b = 64'h1234_5678_9abc_def0; op = 4'd1; valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 hold res", res, held);
        check("R1 idle vld", {63'd0, vld}, 64'd0);
    endtask

    task automatic t_sweep;
        logic [63:0] x, y;
        for (int o = 0; o < 11; o++)
            for (int w = 0; w < 4; w++)
                for (int s = 0; s < 2; s++)
                    for (int n = 0; n < 4; n++) begin
                        x = {$urandom, $urandom};
                        y = {$urandom, $urandom};
                        if (n == 0) y = x;
                        if (n == 1) x = 64'h8080_8000_8000_0000;
                        run_op(4'(o), 2'(w), 1'(s), x, y, req_tag(4'(o), 1'(s)));
                    end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_wrap();
        t_sat_signed();
        t_sat_unsigned();
        t_avg();
        t_minmax();
        t_abs_neg();
        t_unused_op();
        t_hold();
        t_sweep();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule